// File: doc/BRIEF.md
# Prescaled Reload Timer with Square-Wave Output

This block is one timer channel of a small microcontroller-style peripheral. A free-running divider offers the system clock divided by a power of two. A reloadable 8-bit down-counting prescaler counts that divided clock, and a reloadable 8-bit down-counting timer counts the prescaler's underflows. Each counter reloads from its own latch when it steps past zero, so each stage divides by its latch value plus one.

Every timer underflow sets a sticky interrupt request flag, and software clears it by writing a one. In pulse mode the output pin toggles on each underflow and so gives a square wave. Writing the timer presets the pin to a level chosen by a polarity bit, and changing that bit inverts the pin at once.

Software reaches the block through a one-cycle write strobe with a 2-bit register address. Address 0 is the prescaler reload. Address 1 is the timer value. Address 2 is control. Address 3 is the clock source select.

Top module: `reload_timer`

## Requirements
- R1: After synchronous reset, `tmr_count` is 0, `irq` is 0 and `pulse_out` is 1. The block is stopped (control bit 2 = 1), the polarity bit is 0, the mode is 00 and the source select is 0.
- R2: Bits 3:0 of address 3 hold a select value k. The prescaler then counts once every 2^(k+1) clocks of a free-running divider that starts at reset. Any k above 9 acts as 9, which gives 1/1024.
- R3: The prescaler counts down on each source tick and reloads its latch (address 0) when it steps past zero. The timer decrements only on that prescaler underflow. Writing address 0 always loads the latch, and it also loads the prescaler counter while stopped.
- R4: A timer at 0 that receives a count reloads the value its latch held before that cycle, and this is an underflow. With prescaler latch n, timer latch m and select k, underflows come every (m+1)(n+1)2^(k+1) clocks.
- R5: Each underflow sets `irq` on the next clock. The flag stays set until a control write (address 2) with bit 7 = 1 clears it. A clear in the same cycle as an underflow leaves it set.
- R6: While control bit 2 (stop) is 1, neither the prescaler nor the timer counts. A control write with bit 2 = 0 starts counting.
- R7: Writing address 1 always loads the timer latch. It loads `tmr_count` on the next clock only while the block is stopped. While running, the count goes on and the new value appears at the next reload.
- R8: When control bits 1:0 are 01 (pulse mode), `pulse_out` inverts on the clock after each underflow. In mode 00, and in the unused codes 10 and 11, underflows do not change it.
- R9: Writing address 1 sets `pulse_out` on the next clock to the inverse of the polarity bit (control bit 3). This holds in any mode, running or stopped.
- R10: A control write that changes the polarity bit inverts `pulse_out` on the next clock. This combines with an underflow toggle in the same cycle, so the two cancel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register select: 0 prescaler reload, 1 timer, 2 control, 3 source select |
| wr_data | input | W | Write data |
| tmr_count | output | W | Current timer count |
| irq | output | 1 | Sticky underflow interrupt request |
| pulse_out | output | 1 | Square-wave output pin |

## Verification
The bench builds the block with its default parameters: an 8-bit datapath, a 10-stage source divider and a 4-bit select. With these values the clamp of select codes 10 to 15 to the 1/1024 tap can be reached. Random traffic keeps the prescaler and timer latches small, so underflows come often. That puts simultaneous underflow with a flag clear, a polarity change or a timer write within reach. A directed run in pulse mode measures the square-wave half period against the product formula.

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int W          = 8,
  parameter int DIV_STAGES = 10,
  parameter int SELW       = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] tmr_count,
  output logic         irq,
  output logic         pulse_out
);
  localparam int MAXSEL = DIV_STAGES - 1;

  logic [DIV_STAGES-1:0] div_q, mask;
  logic [SELW-1:0]       sel_q, sel_eff;
  logic [W-1:0]          pre_q, pre_lat, tmr_q, tmr_lat;
  logic [1:0]            mode_q;
  logic                  stop_q, pol_q, out_q, irq_q;

  wire wr_pre = wr_en && wr_addr == 2'd0;
  wire wr_tmr = wr_en && wr_addr == 2'd1;
  wire wr_ctl = wr_en && wr_addr == 2'd2;
  wire wr_sel = wr_en && wr_addr == 2'd3;

  assign sel_eff = (int'(sel_q) > MAXSEL) ? SELW'(MAXSEL) : sel_q;

  always_comb begin
    mask = (DIV_STAGES'(2) << sel_eff) - DIV_STAGES'(1);
  end

  wire src_tick = (div_q & mask) == mask;
  wire run      = ~stop_q;
  wire pre_tick = run && src_tick && pre_q == '0;
  wire uf       = pre_tick && tmr_q == '0;
  wire pol_flip = wr_ctl && (wr_data[3] != pol_q);
  wire irq_clr  = wr_ctl && wr_data[7];
  wire pulse_md = mode_q == 2'b01;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      sel_q   <= '0;
      pre_q   <= '0;
      pre_lat <= '0;
      tmr_q   <= '0;
      tmr_lat <= '0;
      mode_q  <= 2'b00;
      stop_q  <= 1'b1;
      pol_q   <= 1'b0;
      out_q   <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      div_q <= div_q + DIV_STAGES'(1);
      if (run && src_tick)
        pre_q <= (pre_q == '0) ? pre_lat : pre_q - W'(1);
      if (wr_pre) begin
        pre_lat <= wr_data;
        if (stop_q) pre_q <= wr_data;
      end
      if (pre_tick)
        tmr_q <= (tmr_q == '0) ? tmr_lat : tmr_q - W'(1);
      if (wr_tmr) begin
        tmr_lat <= wr_data;
        if (stop_q) tmr_q <= wr_data;
      end
      if (wr_ctl) begin
        mode_q <= wr_data[1:0];
        stop_q <= wr_data[2];
        pol_q  <= wr_data[3];
      end
      if (wr_sel) sel_q <= wr_data[SELW-1:0];
      if (wr_tmr) out_q <= ~pol_q;
      else        out_q <= out_q ^ pol_flip ^ (uf && pulse_md);
      irq_q <= uf | (irq_q & ~irq_clr);
    end
  end

  assign tmr_count = tmr_q;
  assign irq       = irq_q;
  assign pulse_out = out_q;

  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (rst) uf |=> irq);
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    uf |=> tmr_count == $past(tmr_lat));
  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !wr_tmr) |=> $stable(tmr_count));
  // R8
  toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (uf && pulse_md && !wr_tmr && !pol_flip) |=> pulse_out != $past(pulse_out));
  // R9
  preset_chk: assert property (@(posedge clk) disable iff (rst)
    wr_tmr |=> pulse_out == !$past(pol_q));
endmodule

// File: tb/reload_timer_tb_top.sv
module reload_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst = 1, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] tmr_count;
  logic       irq, pulse_out;

  reload_timer dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tmr_count(tmr_count), .irq(irq), .pulse_out(pulse_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_vec = 0, n_bad = 0;
  string tag = "R1";
  bit    done = 0;

  logic [9:0] m_div;
  logic [3:0] m_sel;
  logic [7:0] m_pre, m_plat, m_tmr, m_tlat;
  logic [1:0] m_mode;
  logic       m_stop, m_pol, m_out, m_irq;

  function automatic bit src_tick_f(logic [9:0] d, logic [3:0] s);
    int k = (s > 9) ? 9 : s;
    int msk = (1 << (k + 1)) - 1;
    return (int'(d) & msk) == msk;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_sel = 0; m_pre = 0; m_plat = 0; m_tmr = 0; m_tlat = 0;
      m_mode = 0; m_stop = 1; m_pol = 0; m_out = 1; m_irq = 0;
    end else begin
      bit tk, pt, uf, flip;
      logic [7:0] old_tlat;
      tk = src_tick_f(m_div, m_sel);
      pt = !m_stop && tk && m_pre == 0;
      uf = pt && m_tmr == 0;
      old_tlat = m_tlat;
      flip = wr_en && wr_addr == 2 && wr_data[3] != m_pol;
      if (wr_en && wr_addr == 1) m_out = ~m_pol;
      else m_out = m_out ^ flip ^ (uf && m_mode == 2'b01);
      m_irq = uf | (m_irq & !(wr_en && wr_addr == 2 && wr_data[7]));
      if (!m_stop && tk) m_pre = (m_pre == 0) ? m_plat : m_pre - 1;
      if (pt) m_tmr = (m_tmr == 0) ? old_tlat : m_tmr - 1;
      if (wr_en && wr_addr == 0) begin m_plat = wr_data; if (m_stop) m_pre = wr_data; end
      if (wr_en && wr_addr == 1) begin m_tlat = wr_data; if (m_stop) m_tmr = wr_data; end
      if (wr_en && wr_addr == 2) begin
        m_mode = wr_data[1:0]; m_stop = wr_data[2]; m_pol = wr_data[3];
      end
      if (wr_en && wr_addr == 3) m_sel = wr_data[3:0];
      m_div = m_div + 1;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit en, logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    if (!rst) begin
      chk("tmr_count", tmr_count, m_tmr);
      chk("irq", irq, m_irq);
      chk("pulse_out", pulse_out, m_out);
    end
    wr_en = en; wr_addr = a; wr_data = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int last, edges;
    logic prev;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tag = "R1";
    chk("reset tmr_count", tmr_count, 0);
    chk("reset irq", irq, 0);
    chk("reset pulse_out", pulse_out, 1);
    idle(20);

    // R6: stopped counters hold; R7: write while stopped loads count; R9 preset
    tag = "R7 R9";
    cyc(1, 1, 8'd5); cyc(1, 0, 8'd1); idle(2);
    chk("stopped load", tmr_count, 5);
    tag = "R6";
    idle(50);
    chk("stopped hold", tmr_count, 5);

    // R4 / R3 / R8 period: n=2, m=3, k=0 -> 24 clocks between toggles
    tag = "R4 R3 R8";
    cyc(1, 0, 8'd2); cyc(1, 3, 8'd0); cyc(1, 1, 8'd3);
    cyc(1, 2, 8'b0000_0001);
    @(negedge clk); prev = pulse_out; last = -1; edges = 0;
    for (int c = 0; c < 200; c++) begin
      cyc(0, 0, 0);
      if (pulse_out != prev) begin
        if (last >= 0) chk("toggle spacing", c - last, 24);
        last = c; edges++;
      end
      prev = pulse_out;
    end
    chk("toggle count", edges, 8);

    // R5: clears, sticky flag
    tag = "R5";
    cyc(1, 2, 8'b1000_0001); idle(60);
    chk("irq sticky", irq, 1);
    cyc(1, 2, 8'b1000_0001); idle(1);

    // R10: polarity flip while running in pulse mode
    tag = "R10";
    cyc(1, 2, 8'b0000_1001); idle(3);
    cyc(1, 2, 8'b0000_0001); idle(3);

    // R7: timer write while running leaves count
    tag = "R7";
    cyc(1, 1, 8'd7); idle(100);

    // R8: timer mode does not toggle
    tag = "R8";
    cyc(1, 2, 8'b0000_0000); idle(100);

    // R2: clamp of select 12 to 1/1024, latches 0
    tag = "R2";
    cyc(1, 2, 8'b0000_0100); cyc(1, 0, 0); cyc(1, 1, 0);
    cyc(1, 3, 8'd12); cyc(1, 2, 8'b0000_0001);
    idle(2300);
    cyc(1, 3, 8'd3); idle(300);

    // random traffic
    tag = "R3 R4 R5 R8 R9 R10";
    for (int i = 0; i < 20000; i++) begin
      int r = $urandom_range(0, 15);
      if (r < 12) cyc(0, 0, 0);
      else begin
        logic [1:0] a = 2'($urandom_range(0, 3));
        logic [7:0] d;
        case (a)
          2'd0: d = 8'($urandom_range(0, 3));
          2'd1: d = 8'($urandom_range(0, 7));
          2'd2: d = {1'($urandom_range(0, 1)), 3'b000, 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3))};
          default: d = 8'($urandom_range(0, 2));
        endcase
        cyc(1, a, d);
      end
    end
    idle(5);
    finish_run();
  end
endmodule